// File: doc/BRIEF.md
# Stack and Undefined-Memory Fault Monitor

This block watches a small processor's subroutine stack and its accesses to memory that is not populated, and raises a software-interrupt pending flag when an illegal condition shows up. It keeps its own byte-wide stack pointer, which moves with call, interrupt-entry, push, return and pop strobes. It also substitutes fixed values for reads that fall outside the populated program and data memory. A fetch beyond the implemented program space yields the trap opcode 0x00. A data read from an unpopulated region yields 0xFF.

Because of these substitutions, faults surface without a separate detector. Running off the end of program memory executes the trap opcode. Returning more often than calling pops two 0xFF bytes, and these form the all-ones return address, where a trap opcode is expected to sit. The monitor also assembles that return address from the two stack bytes the environment supplies, and it pulses an underflow output whenever a pop reaches into the unpopulated window. The surrounding core, the decoder and the memory arrays are outside the block. The environment feeds the raw array bytes in and takes the substituted bytes back.

Top module: `stkfault_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, the stack pointer becomes 0x6F, and the pending flag and the underflow output become 0.
- R2: At each clock edge the stack pointer drops by 2 for `call_i` (a call or an interrupt entry) and by 1 for `push_i`. It rises by 2 for `ret_i` and by 1 for `pop_i`. Strobes given in the same cycle add up, modulo 256.
- R3: `fetch_data_o` is 0x00 when `fetch_addr_i` >= `rom_limit_i`; otherwise it equals `rom_raw_i`.
- R4: `rd_addr_i` carries the segment in its upper SEG_W bits and the byte offset in its lower 8 bits. In segment 0, offsets 0x70 to 0x7F read as 0xFF. Other offsets in segment 0 pass `ram_raw_i` through.
- R5: A data read whose segment number is >= `seg_limit_i` reads as 0xFF at every offset. The 0x70-0x7F window is not undefined in an implemented segment other than 0.
- R6: `pop_hi_addr_o` is the stack pointer plus 1 and `pop_lo_addr_o` is the stack pointer plus 2 (8-bit). `ret_pc_o` is the low PC_W bits of {high byte, low byte}. Each byte is 0xFF when its address lies in 0x70-0x7F and the raw input otherwise, so after reset `ret_pc_o` is 0x7FFF.
- R7: `underflow_o` is high for the cycle after an edge at which a pop or return was strobed and the stack pointer plus the popped byte count (9-bit sum) was at least 0x70. It is low otherwise.
- R8: The pending flag sets one cycle after an edge where `fetch_valid_i` and `fetch_op_i` are high and `fetch_data_o` is 0x00. This holds whether the zero came from undefined space or from populated memory.
- R9: The pending flag holds its value until a `clr_pend_i` strobe, which clears it at the next edge.
- R10: When a trap and `clr_pend_i` occur in the same cycle, the pending flag is set afterwards.
- R11: An operand fetch (`fetch_op_i` low) of 0x00 does not set the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Call or interrupt entry, pushes two bytes |
| push_i | input | 1 | Single-byte push |
| ret_i | input | 1 | Return, pops two bytes |
| pop_i | input | 1 | Single-byte pop |
| fetch_valid_i | input | 1 | Program fetch valid |
| fetch_op_i | input | 1 | Fetched byte is an opcode to be executed |
| fetch_addr_i | input | PC_W | Program fetch address |
| rom_raw_i | input | 8 | Byte from the program array |
| rom_limit_i | input | PC_W | First unimplemented program address |
| rd_addr_i | input | SEG_W+8 | Data read address (segment, offset) |
| ram_raw_i | input | 8 | Byte from the data array |
| seg_limit_i | input | SEG_W+1 | Number of implemented data segments |
| stk_hi_raw_i | input | 8 | Raw byte at `pop_hi_addr_o` |
| stk_lo_raw_i | input | 8 | Raw byte at `pop_lo_addr_o` |
| clr_pend_i | input | 1 | Clear the pending flag |
| sp_o | output | 8 | Stack pointer |
| fetch_data_o | output | 8 | Substituted fetch byte |
| rd_data_o | output | 8 | Substituted data byte |
| pop_hi_addr_o | output | 8 | Address of the next popped (high) byte |
| pop_lo_addr_o | output | 8 | Address of the second popped (low) byte |
| ret_pc_o | output | PC_W | Return address a return would load |
| underflow_o | output | 1 | Pop reached the unpopulated window |
| swi_pend_o | output | 1 | Software-interrupt pending flag |

## Verification
The bench uses the default widths: PC_W of 15 and SEG_W of 4. The program limit is set to 0x2000 and the segment limit to 2 at run time. This puts the boundary fetch addresses 0x1FFF and 0x2000 and the top address 0x7FFF in reach. It also covers an implemented segment 1, whose 0x70 offset must pass through, and segments 2 and 15, which read as all ones. With the 15-bit program counter, two popped 0xFF bytes land exactly on 0x7FFF. The stack is driven across the 0x6F/0x70 edge with single and double pops.

// File: rtl/stkfault_pkg.sv
package stkfault_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t SP_INIT    = 8'h6F;
    localparam byte_t HOLE_LO    = 8'h70;
    localparam byte_t HOLE_HI    = 8'h7F;
    localparam byte_t TRAP_OP    = 8'h00;
    localparam byte_t FLOAT_BYTE = 8'hFF;

    // bytes moved by the stack strobes of one cycle
    typedef struct packed {
        logic [1:0] down;
        logic [1:0] up;
    } stk_delta_t;

    typedef struct packed {
        logic pend;
        logic underflow;
    } flag_set_t;

    function automatic logic in_hole(input byte_t off);
        return (off >= HOLE_LO) && (off <= HOLE_HI);
    endfunction

    // a call weighs two bytes, a push one: the pair reads as a binary count
    function automatic stk_delta_t make_delta(input logic call, input logic push,
                                              input logic ret, input logic pop);
        stk_delta_t d;
        d.down = {call, push};
        d.up   = {ret, pop};
        return d;
    endfunction

endpackage

// File: rtl/stkfault_sp.sv
module stkfault_sp
    import stkfault_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  call_i,
    input  logic  push_i,
    input  logic  ret_i,
    input  logic  pop_i,
    output byte_t sp_o,
    output logic  underflow_o
);
    stk_delta_t delta;
    logic [BYTE_W:0] reach;
    logic            hits_hole;

    always_comb begin
        delta     = make_delta(call_i, push_i, ret_i, pop_i);
        reach     = {1'b0, sp_o} + {{(BYTE_W-1){1'b0}}, delta.up};
        hits_hole = (delta.up != 2'd0) && (reach >= {1'b0, HOLE_LO});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_o        <= SP_INIT;
            underflow_o <= 1'b0;
        end else begin
            sp_o        <= sp_o + {6'd0, delta.up} - {6'd0, delta.down};
            underflow_o <= hits_hole;
        end
    end
endmodule

// File: rtl/stkfault_fetch_sub.sv
module stkfault_fetch_sub
    import stkfault_pkg::*;
#(
    parameter int PC_W = 15
) (
    input  logic [PC_W-1:0] addr_i,
    input  logic [PC_W-1:0] limit_i,
    input  byte_t           raw_i,
    output byte_t           data_o
);
    always_comb begin
        data_o = (addr_i >= limit_i) ? TRAP_OP : raw_i;
    end
endmodule

// File: rtl/stkfault_data_sub.sv
module stkfault_data_sub
    import stkfault_pkg::*;
#(
    parameter int SEG_W = 4
) (
    input  logic [SEG_W+BYTE_W-1:0] addr_i,
    input  logic [SEG_W:0]          seg_limit_i,
    input  byte_t                   raw_i,
    output byte_t                   data_o
);
    logic [SEG_W-1:0] seg;
    byte_t            off;
    logic             absent_seg;
    logic             seg0_hole;

    always_comb begin
        seg        = addr_i[SEG_W+BYTE_W-1:BYTE_W];
        off        = addr_i[BYTE_W-1:0];
        absent_seg = ({1'b0, seg} >= seg_limit_i);
        seg0_hole  = (seg == '0) && in_hole(off);
        data_o     = (absent_seg || seg0_hole) ? FLOAT_BYTE : raw_i;
    end
endmodule

// File: rtl/stkfault_pend.sv
module stkfault_pend (
    input  logic clk,
    input  logic rst,
    input  logic trap_i,
    input  logic clr_i,
    output logic pend_o
);
    always_ff @(posedge clk) begin
        if (rst)         pend_o <= 1'b0;
        else if (trap_i) pend_o <= 1'b1;
        else if (clr_i)  pend_o <= 1'b0;
    end
endmodule

// File: rtl/stkfault_monitor.sv
module stkfault_monitor
    import stkfault_pkg::*;
#(
    parameter int PC_W  = 15,
    parameter int SEG_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    call_i,
    input  logic                    push_i,
    input  logic                    ret_i,
    input  logic                    pop_i,
    input  logic                    fetch_valid_i,
    input  logic                    fetch_op_i,
    input  logic [PC_W-1:0]         fetch_addr_i,
    input  logic [7:0]              rom_raw_i,
    input  logic [PC_W-1:0]         rom_limit_i,
    input  logic [SEG_W+7:0]        rd_addr_i,
    input  logic [7:0]              ram_raw_i,
    input  logic [SEG_W:0]          seg_limit_i,
    input  logic [7:0]              stk_hi_raw_i,
    input  logic [7:0]              stk_lo_raw_i,
    input  logic                    clr_pend_i,
    output logic [7:0]              sp_o,
    output logic [7:0]              fetch_data_o,
    output logic [7:0]              rd_data_o,
    output logic [7:0]              pop_hi_addr_o,
    output logic [7:0]              pop_lo_addr_o,
    output logic [PC_W-1:0]         ret_pc_o,
    output logic                    underflow_o,
    output logic                    swi_pend_o
);
    localparam int NPOP = 2;

    byte_t     pop_addr [NPOP];
    byte_t     pop_raw  [NPOP];
    byte_t     pop_byte [NPOP];
    logic [2*BYTE_W-1:0] ret_pair;
    flag_set_t flags;
    logic      trap;

    stkfault_sp u_sp (
        .clk        (clk),
        .rst        (rst),
        .call_i     (call_i),
        .push_i     (push_i),
        .ret_i      (ret_i),
        .pop_i      (pop_i),
        .sp_o       (sp_o),
        .underflow_o(flags.underflow)
    );

    stkfault_fetch_sub #(.PC_W(PC_W)) u_fetch (
        .addr_i (fetch_addr_i),
        .limit_i(rom_limit_i),
        .raw_i  (rom_raw_i),
        .data_o (fetch_data_o)
    );

    stkfault_data_sub #(.SEG_W(SEG_W)) u_data (
        .addr_i     (rd_addr_i),
        .seg_limit_i(seg_limit_i),
        .raw_i      (ram_raw_i),
        .data_o     (rd_data_o)
    );

    assign pop_raw[0] = stk_hi_raw_i;
    assign pop_raw[1] = stk_lo_raw_i;

    // stack bytes sit in segment 0 just above the pointer
    for (genvar i = 0; i < NPOP; i++) begin : g_pop
        assign pop_addr[i] = sp_o + byte_t'(i + 1);
        assign pop_byte[i] = in_hole(pop_addr[i]) ? FLOAT_BYTE : pop_raw[i];
    end

    assign pop_hi_addr_o = pop_addr[0];
    assign pop_lo_addr_o = pop_addr[1];
    assign ret_pair      = {pop_byte[0], pop_byte[1]};
    assign ret_pc_o      = PC_W'(ret_pair);

    assign trap = fetch_valid_i && fetch_op_i && (fetch_data_o == TRAP_OP);

    stkfault_pend u_pend (
        .clk   (clk),
        .rst   (rst),
        .trap_i(trap),
        .clr_i (clr_pend_i),
        .pend_o(flags.pend)
    );

    assign underflow_o = flags.underflow;
    assign swi_pend_o  = flags.pend;
endmodule

// File: rtl/stkfault_monitor_chk.sv
module stkfault_monitor_chk #(
    parameter int PC_W  = 15,
    parameter int SEG_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            call_i,
    input logic            push_i,
    input logic            ret_i,
    input logic            pop_i,
    input logic            fetch_valid_i,
    input logic            fetch_op_i,
    input logic [PC_W-1:0] fetch_addr_i,
    input logic [PC_W-1:0] rom_limit_i,
    input logic            clr_pend_i,
    input logic [7:0]      sp_o,
    input logic [7:0]      fetch_data_o,
    input logic            underflow_o,
    input logic            swi_pend_o
);
    logic idle;
    assign idle = !call_i && !push_i && !ret_i && !pop_i;

    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (sp_o == 8'h6F) && !swi_pend_o && !underflow_o);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        idle |=> $stable(sp_o));

    a_r2_call_step: assert property (@(posedge clk) disable iff (rst)
        (call_i && !push_i && !ret_i && !pop_i) |=> (sp_o == $past(sp_o) - 8'd2));

    a_r2_ret_step: assert property (@(posedge clk) disable iff (rst)
        (ret_i && !call_i && !push_i && !pop_i) |=> (sp_o == $past(sp_o) + 8'd2));

    a_r3_undef_rom_zero: assert property (@(posedge clk) disable iff (rst)
        (fetch_addr_i >= rom_limit_i) |-> (fetch_data_o == 8'h00));

    a_r7_underflow_cause: assert property (@(posedge clk) disable iff (rst)
        underflow_o |-> $past(ret_i || pop_i));

    a_r8_trap_sets: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid_i && fetch_op_i && fetch_data_o == 8'h00) |=> swi_pend_o);

    a_r9_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_pend_i && !(fetch_valid_i && fetch_op_i && fetch_data_o == 8'h00))
        |=> !swi_pend_o);

    a_r9_holds_set: assert property (@(posedge clk) disable iff (rst)
        (swi_pend_o && !clr_pend_i) |=> swi_pend_o);
endmodule

bind stkfault_monitor stkfault_monitor_chk #(.PC_W(PC_W), .SEG_W(SEG_W)) chk (
    .clk          (clk),
    .rst          (rst),
    .call_i       (call_i),
    .push_i       (push_i),
    .ret_i        (ret_i),
    .pop_i        (pop_i),
    .fetch_valid_i(fetch_valid_i),
    .fetch_op_i   (fetch_op_i),
    .fetch_addr_i (fetch_addr_i),
    .rom_limit_i  (rom_limit_i),
    .clr_pend_i   (clr_pend_i),
    .sp_o         (sp_o),
    .fetch_data_o (fetch_data_o),
    .underflow_o  (underflow_o),
    .swi_pend_o   (swi_pend_o)
);

// File: tb/stkfault_monitor_test.sv
`timescale 1ns/1ps
module stkfault_monitor_test;
    localparam int PC_W  = 15;
    localparam int SEG_W = 4;
    localparam int NVEC  = 11;

    // {is_data, addr[14:0], raw[7:0], expected[7:0]}
    localparam logic [31:0] VEC [NVEC] = '{
        {1'b0, 15'h0000, 8'h5A, 8'h5A},
        {1'b0, 15'h1FFF, 8'h33, 8'h33},
        {1'b0, 15'h2000, 8'h33, 8'h00},
        {1'b0, 15'h7FFF, 8'hAA, 8'h00},
        {1'b1, 15'h006F, 8'h12, 8'h12},
        {1'b1, 15'h0070, 8'h12, 8'hFF},
        {1'b1, 15'h007F, 8'h00, 8'hFF},
        {1'b1, 15'h0080, 8'h44, 8'h44},
        {1'b1, 15'h0170, 8'h55, 8'h55},
        {1'b1, 15'h0200, 8'h66, 8'hFF},
        {1'b1, 15'h0F00, 8'h01, 8'hFF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic call_i = 0, push_i = 0, ret_i = 0, pop_i = 0;
    logic fetch_valid_i = 0, fetch_op_i = 0, clr_pend_i = 0;
    logic [PC_W-1:0]  fetch_addr_i = '0, rom_limit_i = 15'h2000;
    logic [7:0]       rom_raw_i = '0, ram_raw_i = '0;
    logic [SEG_W+7:0] rd_addr_i = '0;
    logic [SEG_W:0]   seg_limit_i = 5'd2;
    logic [7:0]       stk_hi_raw_i = 8'h12, stk_lo_raw_i = 8'h34;
    logic [7:0]       sp_o, fetch_data_o, rd_data_o, pop_hi_addr_o, pop_lo_addr_o;
    logic [PC_W-1:0]  ret_pc_o;
    logic             underflow_o, swi_pend_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    stkfault_monitor #(.PC_W(PC_W), .SEG_W(SEG_W)) uut (.*);

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk("R1 sp", {8'h00, sp_o}, 16'h006F);
        chk("R1 pend", {15'd0, swi_pend_o}, 16'h0000);
        chk("R1 underflow", {15'd0, underflow_o}, 16'h0000);

        // substitution table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][31]) begin
                rd_addr_i = VEC[i][27:16];
                ram_raw_i = VEC[i][15:8];
                #1;
                chk((VEC[i][27:24] == 4'h0) ? "R4 data" : "R5 data",
                    {8'h00, rd_data_o}, {8'h00, VEC[i][7:0]});
            end else begin
                fetch_addr_i = VEC[i][30:16];
                rom_raw_i    = VEC[i][15:8];
                #1;
                chk("R3 fetch", {8'h00, fetch_data_o}, {8'h00, VEC[i][7:0]});
            end
        end

        // over-popping from the reset pointer
        #1;
        chk("R6 hi addr", {8'h00, pop_hi_addr_o}, 16'h0070);
        chk("R6 lo addr", {8'h00, pop_lo_addr_o}, 16'h0071);
        chk("R6 trap vector", {1'b0, ret_pc_o}, 16'h7FFF);
        ret_i = 1'b1;
        tick();
        ret_i = 1'b0;
        chk("R2 ret", {8'h00, sp_o}, 16'h0071);
        chk("R7 pulse", {15'd0, underflow_o}, 16'h0001);
        tick();
        chk("R7 one cycle", {15'd0, underflow_o}, 16'h0000);

        do_reset();
        call_i = 1'b1;
        tick();
        call_i = 1'b0;
        chk("R2 call", {8'h00, sp_o}, 16'h006D);
        chk("R6 defined bytes", {1'b0, ret_pc_o}, 16'h1234);
        push_i = 1'b1;
        tick();
        push_i = 1'b0;
        chk("R2 push", {8'h00, sp_o}, 16'h006C);
        call_i = 1'b1;
        pop_i  = 1'b1;
        tick();
        call_i = 1'b0;
        pop_i  = 1'b0;
        chk("R2 net", {8'h00, sp_o}, 16'h006B);
        ret_i = 1'b1;
        tick();
        chk("R2 ret step", {8'h00, sp_o}, 16'h006D);
        chk("R7 no pulse", {15'd0, underflow_o}, 16'h0000);
        tick();
        ret_i = 1'b0;
        chk("R7 edge ret", {15'd0, underflow_o}, 16'h0000);
        chk("R2 back home", {8'h00, sp_o}, 16'h006F);
        pop_i = 1'b1;
        tick();
        pop_i = 1'b0;
        chk("R2 pop", {8'h00, sp_o}, 16'h0070);
        chk("R7 single pop", {15'd0, underflow_o}, 16'h0001);

        // pending flag
        do_reset();
        fetch_valid_i = 1'b1;
        fetch_op_i    = 1'b1;
        fetch_addr_i  = 15'h3000;
        rom_raw_i     = 8'h77;
        tick();
        fetch_valid_i = 1'b0;
        chk("R8 undefined fetch", {15'd0, swi_pend_o}, 16'h0001);
        tick();
        chk("R9 hold", {15'd0, swi_pend_o}, 16'h0001);
        clr_pend_i = 1'b1;
        tick();
        clr_pend_i = 1'b0;
        chk("R9 clear", {15'd0, swi_pend_o}, 16'h0000);
        fetch_valid_i = 1'b1;
        fetch_addr_i  = 15'h0100;
        rom_raw_i     = 8'h5A;
        tick();
        chk("R8 nonzero opcode", {15'd0, swi_pend_o}, 16'h0000);
        rom_raw_i = 8'h00;
        tick();
        chk("R8 defined zero", {15'd0, swi_pend_o}, 16'h0001);
        clr_pend_i = 1'b1;
        tick();
        chk("R10 trap wins", {15'd0, swi_pend_o}, 16'h0001);
        fetch_valid_i = 1'b0;
        tick();
        clr_pend_i = 1'b0;
        chk("R9 clear again", {15'd0, swi_pend_o}, 16'h0000);
        fetch_valid_i = 1'b1;
        fetch_op_i    = 1'b0;
        fetch_addr_i  = 15'h3000;
        tick();
        fetch_valid_i = 1'b0;
        chk("R11 operand", {15'd0, swi_pend_o}, 16'h0000);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule